// File: doc/BRIEF.md
# Double-Buffered Backlight PWM Generator

This block drives a single backlight pulse-width-modulated pin. Software programs it over a small memory-mapped write/read bus. It sets a prescaler, a period, a high width and a manual-select bit, then turns generation on with an enable bit. Control writes go into a shadow copy. The live configuration, called the active set, only takes them over after a commit. A commit is a 0-to-1 transition of the commit bit. While generation runs, the transfer waits for the end of the current period, so no partial period is ever produced.

A 2-bit debug field can bypass the double buffer. When it holds 3, the generator uses the shadow settings directly and new writes take effect on the next clock. The prescaler divides the input clock by (divider + 1). The period counter then runs from 0 up to the period value and wraps. The pin is high while the counter is below the high width.

Top module: `bl_pwm_top`

## Requirements
- R1: After reset the pin is low and every register reads back as zero.
- R2: Register map. Offset 0x00 bit 0 is enable. Offset 0x08 bit 0 is commit. Offset 0x10 holds the divider in bits [25:16] and manual-select in bit 1. Offset 0x14 holds the period in bits [11:0] and the high width in bits [28:16]. Offset 0xB0 bits [1:0] are the debug field. Reads return the shadow contents, unused bits read zero, and unmapped offsets read zero.
- R3: In the clock after enable is written to 1, the counter is 0 and the prescaler count is 0. At clock k after that, the pin equals (floor(k/(div+1)) mod (period+1)) < high, provided manual-select is 1.
- R4: A high width greater than the period holds the pin high for the whole period. A high width of 0 holds it low.
- R5: The counter advances once every div+1 input clocks, with div in the range 0 to 1023.
- R6: With the debug field not equal to 3, writes to the control registers do not change the pin until a commit.
- R7: A write that takes commit bit 0 from 0 to 1 schedules a transfer from shadow to active. While generation runs, the transfer happens at the edge where the counter wraps, so the old settings finish the current period.
- R8: With the debug field equal to 3, control register writes change the pin from the next clock on, with no commit.
- R9: While enable is 0, the pin is low and the counter and prescaler are held at 0. Re-enabling restarts the counter from 0.
- R10: When the active manual-select bit is 0, the pin stays low.
- R11: A commit issued while generation is disabled loads the active set on the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also the prescaler input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per clock in which it is high |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | 1 | Backlight PWM pin |

## Verification
The bench sweeps every combination of divider 0 to 2, period 0 to 4 and high width 0 to 6. For each one it compares the pin in every clock of two full periods against the arithmetic formula. This exposes off-by-one errors in the wrap point, in the prescaler count, and in the comparison at high = period and high = period + 1.

A commit is issued in the middle of a period, with new settings that differ from the old ones in the very next cycle. A design that applied the settings at once would drop the pin early. A design that ignored the commit would keep the old pattern after the wrap.

Further scenarios cover control writes without a commit, bypass mode, and disabling in mid-period. These catch shadow writes that leak into the live settings, a bypass that needs an extra clock, and a counter that resumes from its old value instead of restarting.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;

   // bus geometry
   localparam int BUS_AW = 8;
   localparam int BUS_DW = 32;

   // register offsets
   localparam logic [BUS_AW-1:0] OFS_ENABLE = 8'h00;
   localparam logic [BUS_AW-1:0] OFS_COMMIT = 8'h08;
   localparam logic [BUS_AW-1:0] OFS_CTL0   = 8'h10;
   localparam logic [BUS_AW-1:0] OFS_CTL1   = 8'h14;
   localparam logic [BUS_AW-1:0] OFS_DBG    = 8'hB0;

   // field positions
   localparam int EN_BIT     = 0;
   localparam int COMMIT_BIT = 0;
   localparam int MANUAL_BIT = 1;
   localparam int DIV_LSB    = 16;
   localparam int PER_LSB    = 0;
   localparam int HIGH_LSB   = 16;
   localparam int DBG_W      = 2;

   // debug code that bypasses the shadow/active split
   localparam logic [DBG_W-1:0] BYPASS_CODE = 2'b11;

endpackage

// File: rtl/bl_pwm_regs.sv
module bl_pwm_regs
   import bl_pwm_pkg::*;
#(
   parameter int DIV_W     = 10,
   parameter int PER_W     = 12,
   parameter int HIGH_W    = 13,
   parameter bit BYPASS_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [BUS_AW-1:0] addr,
   input  logic [BUS_DW-1:0] wdata,
   output logic [BUS_DW-1:0] rdata,
   output logic              en,
   output logic              bypass,
   output logic              commit_rise,
   output logic              sh_manual,
   output logic [DIV_W-1:0]  sh_div,
   output logic [PER_W-1:0]  sh_per,
   output logic [HIGH_W-1:0] sh_high
);

   // elaboration-time parameter checks
   if (DIV_LSB + DIV_W > BUS_DW) begin : g_bad_div
      $error("divider field does not fit the data word");
   end
   if (HIGH_LSB + HIGH_W > BUS_DW) begin : g_bad_high
      $error("high-width field does not fit the data word");
   end
   if (PER_LSB + PER_W > HIGH_LSB) begin : g_bad_per
      $error("period field overlaps the high-width field");
   end
   if (DIV_LSB <= MANUAL_BIT) begin : g_bad_man
      $error("divider field overlaps the manual-select bit");
   end

   logic hit_en, hit_commit, hit_ctl0, hit_ctl1, hit_dbg;
   logic en_q, commit_q, manual_q;
   logic [DIV_W-1:0]  div_q;
   logic [PER_W-1:0]  per_q;
   logic [HIGH_W-1:0] high_q;
   logic [DBG_W-1:0]  dbg_rd;

   assign hit_en     = wr && (addr == OFS_ENABLE);
   assign hit_commit = wr && (addr == OFS_COMMIT);
   assign hit_ctl0   = wr && (addr == OFS_CTL0);
   assign hit_ctl1   = wr && (addr == OFS_CTL1);
   assign hit_dbg    = wr && (addr == OFS_DBG);

   // a commit counts only on a 0 -> 1 transition of the stored bit
   assign commit_rise = hit_commit && wdata[COMMIT_BIT] && !commit_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q     <= 1'b0;
         commit_q <= 1'b0;
         manual_q <= 1'b0;
         div_q    <= '0;
         per_q    <= '0;
         high_q   <= '0;
      end else begin
         if (hit_en) begin
            en_q <= wdata[EN_BIT];
         end
         if (hit_commit) begin
            commit_q <= wdata[COMMIT_BIT];
         end
         if (hit_ctl0) begin
            manual_q <= wdata[MANUAL_BIT];
            div_q    <= wdata[DIV_LSB +: DIV_W];
         end
         if (hit_ctl1) begin
            per_q  <= wdata[PER_LSB +: PER_W];
            high_q <= wdata[HIGH_LSB +: HIGH_W];
         end
      end
   end

   // debug field exists only when the bypass variant is built
   if (BYPASS_EN) begin : g_dbg
      logic [DBG_W-1:0] dbg_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            dbg_q <= '0;
         end else if (hit_dbg) begin
            dbg_q <= wdata[DBG_W-1:0];
         end
      end
      assign dbg_rd = dbg_q;
      assign bypass = (dbg_q == BYPASS_CODE);
   end else begin : g_no_dbg
      logic unused_dbg_hit;
      assign unused_dbg_hit = hit_dbg;
      assign dbg_rd = '0;
      assign bypass = 1'b0;
   end

   // read path: shadow contents, unused bits zero
   always_comb begin
      rdata = '0;
      unique case (addr)
         OFS_ENABLE: rdata[EN_BIT] = en_q;
         OFS_COMMIT: rdata[COMMIT_BIT] = commit_q;
         OFS_CTL0: begin
            rdata[MANUAL_BIT]         = manual_q;
            rdata[DIV_LSB +: DIV_W]   = div_q;
         end
         OFS_CTL1: begin
            rdata[PER_LSB +: PER_W]   = per_q;
            rdata[HIGH_LSB +: HIGH_W] = high_q;
         end
         OFS_DBG: rdata[DBG_W-1:0] = dbg_rd;
         default: rdata = '0;
      endcase
   end

   assign en        = en_q;
   assign sh_manual = manual_q;
   assign sh_div    = div_q;
   assign sh_per    = per_q;
   assign sh_high   = high_q;

endmodule

// File: rtl/bl_pwm_active.sv
module bl_pwm_active #(
   parameter int CFG_W = 36
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             bypass,
   input  logic             commit_rise,
   input  logic             boundary,
   input  logic [CFG_W-1:0] shadow,
   output logic [CFG_W-1:0] eff,
   output logic             pending
);

   if (CFG_W < 4) begin : g_bad_cfg
      $error("configuration vector too narrow");
   end

   logic [CFG_W-1:0] act_q;
   logic             pend_q;
   logic             load;

   // transfer when scheduled and the generator is idle or wrapping
   assign load = pend_q && (!en || boundary);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= '0;
         pend_q <= 1'b0;
      end else if (bypass) begin
         act_q  <= shadow;
         pend_q <= 1'b0;
      end else begin
         if (load) begin
            act_q <= shadow;
         end
         if (commit_rise) begin
            pend_q <= 1'b1;
         end else if (load) begin
            pend_q <= 1'b0;
         end
      end
   end

   assign eff     = bypass ? shadow : act_q;
   assign pending = pend_q;

   // R7
   hold_mid_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bypass && en && !boundary) |=> $stable(act_q));

   // R11
   idle_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !en && !bypass && !commit_rise) |=> !pend_q);

endmodule

// File: rtl/bl_pwm_gen.sv
module bl_pwm_gen #(
   parameter int DIV_W  = 10,
   parameter int PER_W  = 12,
   parameter int HIGH_W = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              manual,
   input  logic [DIV_W-1:0]  div,
   input  logic [PER_W-1:0]  per,
   input  logic [HIGH_W-1:0] high,
   output logic              pwm,
   output logic              boundary
);

   localparam int CMP_W = (PER_W > HIGH_W) ? PER_W : HIGH_W;

   if (DIV_W < 1 || PER_W < 1 || HIGH_W < 1) begin : g_bad_w
      $error("generator widths must be positive");
   end

   logic [DIV_W-1:0] pre_q;
   logic [PER_W-1:0] cnt_q;
   logic             tick, wrap;

   // >= keeps the counters sane if a bypass write shrinks the limits
   assign tick     = (pre_q >= div);
   assign wrap     = tick && (cnt_q >= per);
   assign boundary = en && wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
         cnt_q <= '0;
      end else if (!en) begin
         pre_q <= '0;
         cnt_q <= '0;
      end else begin
         pre_q <= tick ? '0 : pre_q + DIV_W'(1);
         if (tick) begin
            cnt_q <= wrap ? '0 : cnt_q + PER_W'(1);
         end
      end
   end

   assign pwm = en && manual && (CMP_W'(cnt_q) < CMP_W'(high));

   // R3
   wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      boundary |=> (cnt_q == '0 || !en));

   // R9
   restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (cnt_q == '0 && pre_q == '0));

   // R5
   prescale_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && $past(en) && !tick) |=> $stable(cnt_q));

endmodule

// File: rtl/bl_pwm_top.sv
module bl_pwm_top
   import bl_pwm_pkg::*;
#(
   parameter int DIV_W     = 10,
   parameter int PER_W     = 12,
   parameter int HIGH_W    = 13,
   parameter bit BYPASS_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic [BUS_DW-1:0] bus_wdata,
   output logic [BUS_DW-1:0] bus_rdata,
   output logic              pwm_out
);

   localparam int CFG_W = 1 + DIV_W + PER_W + HIGH_W;

   logic              en, bypass, commit_rise, boundary, pending;
   logic              sh_manual, ef_manual;
   logic [DIV_W-1:0]  sh_div, ef_div;
   logic [PER_W-1:0]  sh_per, ef_per;
   logic [HIGH_W-1:0] sh_high, ef_high;
   logic [CFG_W-1:0]  sh_vec, ef_vec;

   bl_pwm_regs #(
      .DIV_W(DIV_W), .PER_W(PER_W), .HIGH_W(HIGH_W), .BYPASS_EN(BYPASS_EN)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
      .wdata(bus_wdata), .rdata(bus_rdata), .en(en), .bypass(bypass),
      .commit_rise(commit_rise), .sh_manual(sh_manual), .sh_div(sh_div),
      .sh_per(sh_per), .sh_high(sh_high)
   );

   assign sh_vec = {sh_manual, sh_div, sh_per, sh_high};

   bl_pwm_active #(.CFG_W(CFG_W)) u_active (
      .clk(clk), .rst_n(rst_n), .en(en), .bypass(bypass),
      .commit_rise(commit_rise), .boundary(boundary),
      .shadow(sh_vec), .eff(ef_vec), .pending(pending)
   );

   assign {ef_manual, ef_div, ef_per, ef_high} = ef_vec;

   bl_pwm_gen #(.DIV_W(DIV_W), .PER_W(PER_W), .HIGH_W(HIGH_W)) u_gen (
      .clk(clk), .rst_n(rst_n), .en(en), .manual(ef_manual),
      .div(ef_div), .per(ef_per), .high(ef_high),
      .pwm(pwm_out), .boundary(boundary)
   );

   // R9
   off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> !pwm_out);

   // R8
   bypass_no_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bypass |=> !pending);

endmodule

// File: tb/tb_bl_pwm_top.sv
`timescale 1ns/1ps
module tb_bl_pwm_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        pwm_out;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   bl_pwm_top dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
   );

   always #10 clk = ~clk;

   task automatic chk(input logic got, input logic exp, input string tag);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: pwm got %0b expected %0b", tag, got, exp);
      end
   endtask

   task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
      bus_addr = a;
      #1;
      total++;
      if (bus_rdata !== exp) begin
         bad++;
         $display("FAIL %s: read %h got %h expected %h", tag, a, bus_rdata, exp);
      end
   endtask

   // disable, program, commit while idle, enable; returns at clock k=0
   task automatic setup(input int dv, input int pr, input int hi, input bit man);
      wr_reg(8'h00, 32'h0);
      wr_reg(8'h10, (32'(dv) << 16) | (32'(man) << 1));
      wr_reg(8'h14, (32'(hi) << 16) | 32'(pr));
      wr_reg(8'h08, 32'h1);
      wr_reg(8'h08, 32'h0);
      wr_reg(8'h00, 32'h1);
   endtask

   function automatic logic model(input int k, input int dv, input int pr, input int hi);
      return ((k / (dv + 1)) % (pr + 1)) < hi;
   endfunction

   initial begin
      #3_000_000;
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(pwm_out, 1'b0, "R1 pin after reset");
      rd_chk(8'h00, 32'h0, "R1");
      rd_chk(8'h10, 32'h0, "R1");
      rd_chk(8'h14, 32'h0, "R1");
      rd_chk(8'hB0, 32'h0, "R1");
      rst_n = 1'b1;
      @(negedge clk);

      // R2 readback with all-ones writes
      wr_reg(8'h10, 32'hFFFF_FFFF);
      wr_reg(8'h14, 32'hFFFF_FFFF);
      wr_reg(8'h00, 32'hFFFF_FFFF);
      wr_reg(8'h08, 32'hFFFF_FFFF);
      wr_reg(8'hB0, 32'hFFFF_FFFF);
      rd_chk(8'h10, 32'h03FF_0002, "R2 ctl0");
      rd_chk(8'h14, 32'h1FFF_0FFF, "R2 ctl1");
      rd_chk(8'h00, 32'h0000_0001, "R2 enable");
      rd_chk(8'h08, 32'h0000_0001, "R2 commit");
      rd_chk(8'hB0, 32'h0000_0003, "R2 debug");
      rd_chk(8'hFC, 32'h0000_0000, "R2 unmapped");
      wr_reg(8'hB0, 32'h0);
      wr_reg(8'h08, 32'h0);
      wr_reg(8'h00, 32'h0);

      // R10 manual-select clear keeps pin low
      setup(0, 3, 9, 1'b0);
      for (int k = 0; k < 8; k++) begin
         chk(pwm_out, 1'b0, "R10 manual off");
         @(negedge clk);
      end

      // R11 commit while disabled loads active at once
      setup(0, 3, 2, 1'b1);
      chk(pwm_out, 1'b1, "R11 idle commit applied");

      // R6 / R7 deferred commit: k=0 now
      wr_reg(8'h14, (32'd0 << 16) | 32'd3);
      for (int k = 1; k < 8; k++) begin
         chk(pwm_out, model(k, 0, 3, 2), "R6 shadow write ignored");
         @(negedge clk);
      end
      wr_reg(8'h08, 32'h1);            // commit at k=8, now k=9
      for (int k = 9; k < 20; k++) begin
         chk(pwm_out, (k < 12) ? model(k, 0, 3, 2) : 1'b0, "R7 applied at wrap");
         @(negedge clk);
      end
      wr_reg(8'h08, 32'h0);

      // R9 disable mid-period, low while off, restart from 0
      setup(1, 3, 2, 1'b1);
      repeat (3) @(negedge clk);
      wr_reg(8'h00, 32'h0);
      for (int k = 0; k < 4; k++) begin
         chk(pwm_out, 1'b0, "R9 low while disabled");
         @(negedge clk);
      end
      wr_reg(8'h00, 32'h1);
      for (int k = 0; k < 10; k++) begin
         chk(pwm_out, model(k, 1, 3, 2), "R9 restart from zero");
         @(negedge clk);
      end

      // R8 bypass: writes act on the next clock
      wr_reg(8'h00, 32'h0);
      wr_reg(8'hB0, 32'h3);
      wr_reg(8'h10, 32'h2);
      wr_reg(8'h14, (32'd4 << 16) | 32'd3);
      wr_reg(8'h00, 32'h1);
      chk(pwm_out, 1'b1, "R8 bypass initial");
      wr_reg(8'h14, (32'd0 << 16) | 32'd3);
      chk(pwm_out, 1'b0, "R8 bypass next clock");
      @(negedge clk);
      chk(pwm_out, 1'b0, "R8 bypass holds");
      wr_reg(8'hB0, 32'h0);

      // R3 R4 R5 sweep
      for (int dv = 0; dv < 3; dv++) begin
         for (int pr = 0; pr < 5; pr++) begin
            for (int hi = 0; hi < 7; hi++) begin
               string tag;
               tag = (hi > pr || hi == 0) ? "R4 sweep" : ((dv > 0) ? "R5 sweep" : "R3 sweep");
               setup(dv, pr, hi, 1'b1);
               for (int k = 0; k < 2 * (dv + 1) * (pr + 1) + 2; k++) begin
                  chk(pwm_out, model(k, dv, pr, hi), tag);
                  @(negedge clk);
               end
            end
         end
      end

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule